// File: doc/BRIEF.md
# Chunky-to-Planar Pixel Transposer

This block turns packed 8-bit pixels into bitplane words. Software writes 32 pixels through one register address, four pixels in each 32-bit write. It then reads eight 32-bit words back through the same address. Each word gathers one bit position from all 32 pixels. This replaces a shift-and-mask loop that a processor would otherwise run for every group of pixels before it stores bitplane data.

The port has separate write and read strobes. The read data is always valid: it shows the plane that the read pointer currently selects, and a read strobe moves the pointer on to the next plane. After a full pass of eight reads, the next write starts a new load and clears the pixel buffer first. A change of level on the resync input puts both pointers back to zero and arms a new load in the same way. Any strobe in that cycle is dropped.

Top module: `c2p_xpose`

## Requirements
- R1: After reset the pixel buffer holds all zeros and both pointers are at zero, so every plane reads 0x00000000.
- R2: Each write carries four pixels. Bits 31:24 hold the leftmost pixel and bits 7:0 the rightmost. Write number g (counted from 0 within a load) fills pixels 4g to 4g+3.
- R3: Bit (31-p) of plane word k equals bit k of pixel p, so pixel 0 lands in bit 31.
- R4: `rdata` shows the plane chosen by the read pointer without any strobe. Each read strobe advances the pointer, and the planes come out in order from plane 0 to plane 7.
- R5: The read pointer wraps modulo 8. After plane 7 is read, plane 0 is presented again.
- R6: After eight reads complete a pass, the next write starts a new load. It clears all 32 pixels and then stores its own four pixels as pixels 0 to 3.
- R7: A read started before all eight writes of a load returns planes built from the partly filled buffer. Pixels that have not yet been written in the new load read as zero.
- R8: A partial read pass (fewer than eight reads) does not start a new load. Later writes go on filling from the current write position.
- R9: The write pointer wraps modulo 8. A ninth write with no full read pass in between overwrites pixels 0 to 3 and leaves the other pixels unchanged.
- R10: Any change of `sync_mode` sets both pointers to zero and arms a new load. Read and write strobes in that same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | Resync level; each change resets the pointers and arms a new load |
| wr_en | input | 1 | Write strobe: store four pixels from `wdata` |
| wdata | input | 32 | Four packed pixels, leftmost pixel in the top byte |
| rd_en | input | 1 | Read strobe: advance to the next plane |
| rdata | output | 32 | Currently selected plane word, pixel 0 in bit 31 |

## Verification
The assertions assume that the write and read strobes are never high in the same cycle. The write slot and the re-arm of a new load are only checked for strobes on their own. The stimulus gives each cycle exactly one action: a write, a read, a resync toggle or idle. The random phase draws one action per cycle from these four, and the directed cases raise a strobe together with a `sync_mode` toggle only to show that the strobe is dropped.

// File: rtl/c2p_pkg.sv
package c2p_pkg;

  // Lowest bit index of a lane in a write word; lane 0 sits in the top byte.
  function automatic int lane_lsb(int lane, int lanes, int pw);
    return (lanes - 1 - lane) * pw;
  endfunction

  // Bit index inside a plane word that carries pixel 'pix'; pixel 0 is the MSB.
  function automatic int plane_bit(int pix, int npix);
    return npix - 1 - pix;
  endfunction

  // Pixel number for lane 'lane' of write group 'grp'.
  function automatic int pix_index(int grp, int lane, int lanes);
    return grp * lanes + lane;
  endfunction

endpackage

// File: rtl/c2p_wrap_ptr.sv
module c2p_wrap_ptr #(
  parameter int DEPTH = 8,
  localparam int W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load1,
  input  logic         step,
  output logic [W-1:0] ptr,
  output logic         at_last
);

  assign at_last = (ptr == W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (load1)  ptr <= W'(1);
    else if (step)   ptr <= at_last ? '0 : ptr + W'(1);
  end

  // R5 / R9: a plain step moves by one and wraps after the last slot
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load1) |=>
      (ptr == ($past(at_last) ? W'(0) : $past(ptr) + W'(1))));

  // R10: a clear always lands on zero
  a_r10_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));

  // idle keeps the pointer
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load1 && !step) |=> $stable(ptr));

endmodule

// File: rtl/c2p_seq_ctl.sv
module c2p_seq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic wr_en,
  input  logic rd_en,
  input  logic rd_last,
  output logic mode_chg,
  output logic wr_fire,
  output logic rd_fire,
  output logic rd_wrap,
  output logic load_start
);

  logic mode_q;
  logic armed;

  assign mode_chg   = sync_mode ^ mode_q;
  assign wr_fire    = wr_en & ~mode_chg;
  assign rd_fire    = rd_en & ~mode_chg;
  assign rd_wrap    = rd_fire & rd_last;
  assign load_start = wr_fire & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      mode_q <= sync_mode;
      if (mode_chg || rd_wrap) armed <= 1'b1;
      else if (wr_fire)        armed <= 1'b0;
    end
  end

  // R6: a completed read pass arms a new load
  a_r6_arm_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap |=> armed);

  // R10: a resync arms a new load and drops the strobes
  a_r10_arm_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> armed);
  a_r10_strobes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (!wr_fire && !rd_fire));

  // R6: a load start consumes the arm when no read is in flight
  a_r6_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (load_start && !rd_en) |=> !armed);

  // R8: a read that does not wrap leaves the arm alone
  a_r8_partial_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_last && !wr_en) |=> (armed == $past(armed)));

endmodule

// File: rtl/c2p_pix_store.sv
module c2p_pix_store
  import c2p_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LANES  = 4,
  parameter int GROUPS = 8,
  localparam int NPIX   = LANES * GROUPS,
  localparam int DATA_W = LANES * PIX_W,
  localparam int SLOT_W = $clog2(GROUPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   clr,
  input  logic [SLOT_W-1:0]      slot,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NPIX*PIX_W-1:0]  pix_flat
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int P   = pix_index(g, l, LANES);
      localparam int LSB = lane_lsb(l, LANES, PIX_W);
      logic [PIX_W-1:0] px;

      always_ff @(posedge clk) begin
        if (!rst_n)
          px <= '0;
        else if (clr)
          px <= (g == 0) ? wdata[LSB +: PIX_W] : '0;
        else if (wr && slot == SLOT_W'(g))
          px <= wdata[LSB +: PIX_W];
      end

      assign pix_flat[P*PIX_W +: PIX_W] = px;
    end
  end

  // R2: the top byte of a write to slot 0 becomes pixel 0
  a_r2_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && slot == '0) |=>
      (pix_flat[PIX_W-1:0] == $past(wdata[DATA_W-1 -: PIX_W])));

  // R6: starting a new load clears the last pixel
  if (GROUPS > 1) begin : g_tail_chk
    a_r6_clear_tail: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pix_flat[NPIX*PIX_W-1 -: PIX_W] == '0));
  end

endmodule

// File: rtl/c2p_plane_mux.sv
module c2p_plane_mux
  import c2p_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int NPIX  = 32,
  localparam int SEL_W = $clog2(PIX_W)
) (
  input  logic [NPIX*PIX_W-1:0] pix_flat,
  input  logic [SEL_W-1:0]      plane,
  output logic [NPIX-1:0]       rdata
);

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPIX; p++) begin
      rdata[plane_bit(p, NPIX)] = pix_flat[p*PIX_W + int'(plane)];
    end
  end

endmodule

// File: rtl/c2p_xpose.sv
module c2p_xpose #(
  parameter int PIX_W  = 8,
  parameter int LANES  = 4,
  parameter int GROUPS = 8,
  localparam int NPIX   = LANES * GROUPS,
  localparam int DATA_W = LANES * PIX_W,
  localparam int WP_W   = $clog2(GROUPS),
  localparam int RP_W   = $clog2(PIX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [NPIX-1:0]   rdata
);

  // named internal events
  logic            mode_chg, wr_fire, rd_fire, rd_wrap, load_start;
  logic [WP_W-1:0] wptr, wr_slot;
  logic [RP_W-1:0] rptr;
  logic            wp_last, rp_last;
  logic [NPIX*PIX_W-1:0] pix_flat;

  c2p_seq_ctl u_seq (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .wr_en(wr_en), .rd_en(rd_en), .rd_last(rp_last),
    .mode_chg(mode_chg), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .rd_wrap(rd_wrap), .load_start(load_start)
  );

  c2p_wrap_ptr #(.DEPTH(GROUPS)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .load1(load_start),
    .step(wr_fire), .ptr(wptr), .at_last(wp_last)
  );

  c2p_wrap_ptr #(.DEPTH(PIX_W)) u_rptr (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .load1(1'b0),
    .step(rd_fire), .ptr(rptr), .at_last(rp_last)
  );

  assign wr_slot = load_start ? '0 : wptr;

  c2p_pix_store #(.PIX_W(PIX_W), .LANES(LANES), .GROUPS(GROUPS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(wr_fire), .clr(load_start),
    .slot(wr_slot), .wdata(wdata), .pix_flat(pix_flat)
  );

  c2p_plane_mux #(.PIX_W(PIX_W), .NPIX(NPIX)) u_mux (
    .pix_flat(pix_flat), .plane(rptr), .rdata(rdata)
  );

  // R10: both pointers at zero after a resync
  a_r10_ptrs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (wptr == '0 && rptr == '0));

  // R6: a new load leaves the write pointer on the second slot
  a_r6_load_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (load_start && GROUPS > 1) |=> (wptr == WP_W'(1)));

  // R9: the eighth write of a load wraps the write pointer
  a_r9_wptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wp_last && !load_start) |=> (wptr == '0));

  // R5: a wrapping read presents plane 0 next
  a_r5_rd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap |=> (rptr == '0));

  // R4: the read data does not move without a read strobe, a write or a resync
  a_r4_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !mode_chg) |=> $stable(rdata));

endmodule

// File: tb/c2p_xpose_test.sv
module c2p_xpose_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench view of the block, built from the requirements
  logic [7:0] mpix [32];
  int  mwp = 0;
  int  mrp = 0;
  bit  marm = 1'b0;
  bit  mmode = 1'b0;

  always #4 clk = ~clk;

  c2p_xpose uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // plane word: walk pixels left to right, shifting bit k of each in from the right
  function automatic logic [31:0] exp_plane(int k);
    logic [31:0] acc = '0;
    for (int p = 0; p < 32; p++) acc = {acc[30:0], mpix[p][k]};
    return acc;
  endfunction

  task automatic drive(bit w, bit r, bit m, logic [31:0] d, string tag);
    logic [31:0] e;
    @(negedge clk);
    wr_en = w; rd_en = r; sync_mode = m; wdata = d;
    #1;
    if (m != mmode) begin
      mmode = m; mwp = 0; mrp = 0; marm = 1'b1;
    end else begin
      if (r) begin
        e = exp_plane(mrp);
        chk(rdata == e, tag, rdata, e);
        mrp = (mrp + 1) % 8;
        if (mrp == 0) marm = 1'b1;
      end
      if (w) begin
        if (marm) begin
          for (int p = 0; p < 32; p++) mpix[p] = 8'h00;
          mwp = 0; marm = 1'b0;
        end
        for (int l = 0; l < 4; l++) mpix[mwp*4 + l] = d[31 - 8*l -: 8];
        mwp = (mwp + 1) % 8;
      end
    end
  endtask

  task automatic idle_lit(logic [31:0] exp, string tag);
    drive(1'b0, 1'b0, mmode, 32'h0, "");
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    int op;
    for (int p = 0; p < 32; p++) mpix[p] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, plane 0 shown without a strobe, then a full pass of zeros
    idle_lit(32'h0, "R1 reset plane0");
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b1, mmode, 32'h0, "R1 reset pass");

    // R3: one set bit in pixel 0 lands in bit 31 of plane 0
    drive(1'b1, 1'b0, mmode, 32'h0100_0000, "");
    for (int g = 1; g < 8; g++) drive(1'b1, 1'b0, mmode, 32'h0, "");
    idle_lit(32'h8000_0000, "R3 pixel0 to bit31");
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b1, mmode, 32'h0, "R4 plane order");

    // R2: pixel p holds value p
    for (int g = 0; g < 8; g++)
      drive(1'b1, 1'b0, mmode,
            {8'(4*g), 8'(4*g+1), 8'(4*g+2), 8'(4*g+3)}, "");
    idle_lit(32'h5555_5555, "R2 packing plane0");
    for (int k = 0; k < 8; k++) drive(1'b0, 1'b1, mmode, 32'h0, "R2 R3 ramp planes");
    // R5: after plane 7 the pointer is back on plane 0
    idle_lit(32'h5555_5555, "R5 read wrap");

    // R6 / R7: new load clears, partial read sees only the written pixels
    for (int g = 0; g < 3; g++) drive(1'b1, 1'b0, mmode, 32'hFFFF_FFFF, "");
    idle_lit(32'hFFF0_0000, "R7 partial buffer");
    drive(1'b0, 1'b1, mmode, 32'h0, "R7 partial read");
    drive(1'b0, 1'b1, mmode, 32'h0, "R7 partial read");
    // R8: the partial pass does not restart the load
    drive(1'b1, 1'b0, mmode, 32'hFFFF_FFFF, "");
    idle_lit(32'hFFFF_0000, "R8 continue after partial read");
    for (int k = 0; k < 6; k++) drive(1'b0, 1'b1, mmode, 32'h0, "R8 finish pass");

    // R9: nine writes, the ninth overwrites pixels 0..3 only
    for (int g = 0; g < 8; g++) drive(1'b1, 1'b0, mmode, 32'hAAAA_AAAA, "");
    drive(1'b1, 1'b0, mmode, 32'h0, "");
    idle_lit(32'h0, "R9 plane0 after wrap");
    drive(1'b0, 1'b1, mmode, 32'h0, "R9 read plane0");
    idle_lit(32'h0FFF_FFFF, "R9 plane1 after wrap");

    // R10: toggle with a write strobe; the write is dropped, pointers reset
    drive(1'b1, 1'b0, ~mmode, 32'hFFFF_FFFF, "");
    idle_lit(32'h0, "R10 write dropped, plane0");
    drive(1'b0, 1'b1, mmode, 32'h0, "R10 read after toggle");
    idle_lit(32'h0FFF_FFFF, "R10 buffer kept");
    drive(1'b0, 1'b1, ~mmode, 32'h0, "");
    idle_lit(32'h0, "R10 read dropped, plane0");
    // R6: first write after a resync starts a new load
    drive(1'b1, 1'b0, mmode, 32'h0101_0101, "");
    idle_lit(32'hF000_0000, "R6 new load after toggle");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      op = int'($urandom_range(99));
      if (op < 45)      drive(1'b1, 1'b0, mmode, $urandom, "");
      else if (op < 90) drive(1'b0, 1'b1, mmode, 32'h0, "R4 R6 R7 random read");
      else if (op < 95) drive(1'b0, 1'b0, ~mmode, 32'h0, "");
      else              idle_lit(exp_plane(mrp), "R4 random idle view");
    end

    drive(1'b0, 1'b0, mmode, 32'h0, "");
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule